// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

The block is one memory-mapped timer with a 32-bit register port. Once enabled, its counter steps down by one on each tick. Ticks come from a prescaler that divides the clock by 1, 16 or 256. The counter can be 16 or 32 bits wide and runs in one of three modes.

- **Free-running:** the counter wraps through the full range.
- **Periodic:** the counter restarts from a programmed limit each time it reaches zero.
- **One-shot:** the counter stops at zero.

When the counter steps from one to zero, the block latches a raw interrupt flag. The interrupt line is that flag gated by an enable bit in the control register.

Software writes a limit and then programs the control register. A write to the limit register restarts the count at once. A second limit register replaces the limit for the next wrap and leaves the current count alone. Interrupts are handled through raw and masked status reads and a write-any-value clear register.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable set, timer stopped). The count, limit, raw status, masked status and `irq` are all 0.
- R2: Accesses are 32-bit words selected by byte address bits [7:2]: 0 load, 1 count, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background load. An access is only valid when byte address bits [1:0] are 0; any other address is undefined. Undefined addresses read 0 and ignore writes. The control register keeps bits [7:0] as written. Writes to the count register are ignored.
- R3: Control bits [3:2] pick the prescale: 00 steps every cycle, 01 every 16 cycles, 10 every 256 cycles, 11 every cycle. The first step comes that many cycles after the enabling control write.
- R4: A write to the load register stores the limit and sets the count to the effective limit on the same edge. A write to the background load register stores the limit and leaves the count unchanged. Both addresses read back the stored limit.
- R5: In periodic mode (control bit 6) the count runs L, L-1, … 0 and then reloads L, so one period is L+1 steps.
- R6: With bits 6 and 0 both clear the timer is free-running and the effective limit is all ones. Control bit 1 selects 32-bit counting; when it is clear, the count, the limit used and the wrap are 16 bits (0xFFFF).
- R7: In one-shot mode (control bit 0) the count stops at zero. It restarts only when the load register is written or the control register is written with the enable bit set.
- R8: The raw flag sets on the step that takes the count from 1 to 0. Any write to the clear register clears it. If a clear and a setting step fall on the same edge, the flag ends up set.
- R9: `irq` and the masked status both equal the raw flag AND control bit 5. The raw status ignores bit 5.
- R10: A control write with bit 7 set reloads the count from the effective limit under the new settings and restarts the prescaler. While bit 7 is clear the count does not change, except through the load register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
A register write can land on the same edge as a counter step. Two such collisions are provoked on purpose:

- **Clear against zero-crossing:** a periodic timer with limit 2 runs on an undivided tick, and the interrupt-clear write is placed on exactly the edge where the count steps from 1 to 0. The raw status must still read 1, and a second clear one cycle later must leave it at 0.
- **Limit writes against a step:** a load write and a background-load write are each placed on a stepping edge. The load write must win outright. The background write must let the step go through and only change the value used at the next wrap.

All expected counts come from step arithmetic on the cycle number since the enabling write.

// File: rtl/itmr_pkg.sv
`timescale 1ns/1ps
package itmr_pkg;

    localparam int unsigned DATA_W = 32;

    // word index of each register (byte address bits above the word offset)
    typedef enum logic [2:0] {
        OFF_LOAD   = 3'd0,
        OFF_VALUE  = 3'd1,
        OFF_CTRL   = 3'd2,
        OFF_ICLR   = 3'd3,
        OFF_RAW    = 3'd4,
        OFF_MASKED = 3'd5,
        OFF_BGLOAD = 3'd6
    } reg_off_e;

    // control byte, MSB first: bit7 enable ... bit0 one-shot
    typedef struct packed {
        logic       enable;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] psel;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [DATA_W-1:0]  limit;
    } regs_t;

endpackage

// File: rtl/itmr_prescale.sv
`timescale 1ns/1ps
module itmr_prescale #(
    parameter int unsigned DIV_A_LOG2 = 4,
    parameter int unsigned DIV_B_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);

    localparam int unsigned PW = (DIV_B_LOG2 > DIV_A_LOG2) ? DIV_B_LOG2 : DIV_A_LOG2;
    localparam logic [PW-1:0] TERM_A = {PW{1'b1}} >> (PW - DIV_A_LOG2);
    localparam logic [PW-1:0] TERM_B = {PW{1'b1}} >> (PW - DIV_B_LOG2);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PW-1:0] term;

    always_comb begin
        case (sel)
            2'b01:   term = TERM_A;
            2'b10:   term = TERM_B;
            default: term = '0;
        endcase

        tick = run && (st_q.cnt == term);

        st_d = st_q;
        if (!run || restart || (st_q.cnt == term)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a divided tick is never followed by another tick on the next cycle
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !restart && (sel == 2'b01 || sel == 2'b10) && tick |=> !tick); // R3

endmodule

// File: rtl/itmr_count.sv
`timescale 1ns/1ps
module itmr_count #(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wide,
    input  logic             oneshot,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] wrap_val,
    input  logic             clr_req,
    output logic [CNT_W-1:0] count_o,
    output logic             raw_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             raw;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cur;
    logic             at_zero;
    logic             at_one;
    logic             hit;

    generate
        if (NARROW_W >= CNT_W) begin : g_no_narrow
            assign mask = '1;
        end else begin : g_narrow
            localparam logic [CNT_W-1:0] NARROW_MASK =
                {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
            assign mask = wide ? {CNT_W{1'b1}} : NARROW_MASK;
        end
    endgenerate

    always_comb begin
        cur     = st_q.count & mask;
        at_zero = (cur == '0);
        at_one  = (cur == CNT_W'(1));
        hit     = tick && !reload_req && at_one;

        st_d = st_q;
        if (reload_req) begin
            st_d.count = reload_val;
        end else if (tick) begin
            if (at_zero) begin
                if (!oneshot) begin
                    st_d.count = wrap_val;
                end
            end else begin
                st_d.count = (cur - CNT_W'(1)) & mask;
            end
        end

        if (clr_req) begin
            st_d.raw = 1'b0;
        end
        if (hit) begin
            st_d.raw = 1'b1;
        end
    end

    assign count_o = cur;
    assign raw_o   = st_q.raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        tick && oneshot && !reload_req && (count_o == '0) |=> (count_o == '0)); // R7

    AST_RAW_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !reload_req && (count_o == CNT_W'(1)) |=> raw_o); // R8

    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && !(tick && (count_o == CNT_W'(1))) |=> !raw_o); // R8

    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !reload_req |=> $stable(st_q.count)); // R10

    AST_RELOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> (st_q.count == $past(reload_val))); // R4

endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
    import itmr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NARROW_W   = 16,
    parameter int unsigned DIV_A_LOG2 = 4,
    parameter int unsigned DIV_B_LOG2 = 8,
    parameter logic [7:0]  CTRL_RST   = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);

    localparam int unsigned CNT_W = DATA_W;
    localparam int unsigned OFF_W = ADDR_W - 2;
    localparam logic [CNT_W-1:0] NARROW_MASK =
        (NARROW_W >= CNT_W) ? {CNT_W{1'b1}} : ({CNT_W{1'b1}} >> (CNT_W - NARROW_W));

    regs_t regs_d, regs_q;

    logic [OFF_W-1:0] off;
    logic [2:0]       sel_off;
    logic             acc_ok;
    logic             wr_load, wr_bg, wr_ctrl, wr_iclr;
    logic             reload_req;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] wrap_val;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             raw;

    function automatic logic [CNT_W-1:0] eff_limit(input ctrl_t c, input logic [CNT_W-1:0] lim);
        logic [CNT_W-1:0] m;
        m = c.wide ? {CNT_W{1'b1}} : NARROW_MASK;
        return (c.periodic || c.oneshot) ? (lim & m) : m;
    endfunction

    // address decode
    always_comb begin
        off     = addr[ADDR_W-1:2];
        sel_off = off[2:0];
        acc_ok  = (addr[1:0] == 2'b00) && ((off >> 3) == '0) && (sel_off != 3'd7);
        wr_load = wr_en && acc_ok && (sel_off == OFF_LOAD);
        wr_bg   = wr_en && acc_ok && (sel_off == OFF_BGLOAD);
        wr_ctrl = wr_en && acc_ok && (sel_off == OFF_CTRL);
        wr_iclr = wr_en && acc_ok && (sel_off == OFF_ICLR);
    end

    // register next state
    always_comb begin
        regs_d = regs_q;
        if (wr_load || wr_bg) begin
            regs_d.limit = wdata;
        end
        if (wr_ctrl) begin
            regs_d.ctrl = ctrl_t'(wdata[7:0]);
        end
        reload_req = wr_load || (wr_ctrl && regs_d.ctrl.enable);
        reload_val = eff_limit(regs_d.ctrl, regs_d.limit);
        wrap_val   = eff_limit(regs_q.ctrl, regs_q.limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.ctrl  <= ctrl_t'(CTRL_RST);
        end else begin
            regs_q <= regs_d;
        end
    end

    itmr_prescale #(
        .DIV_A_LOG2 (DIV_A_LOG2),
        .DIV_B_LOG2 (DIV_B_LOG2)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (regs_q.ctrl.enable),
        .restart (wr_ctrl),
        .sel     (regs_q.ctrl.psel),
        .tick    (tick)
    );

    itmr_count #(
        .CNT_W    (CNT_W),
        .NARROW_W (NARROW_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wide       (regs_q.ctrl.wide),
        .oneshot    (regs_q.ctrl.oneshot),
        .reload_req (reload_req),
        .reload_val (reload_val),
        .wrap_val   (wrap_val),
        .clr_req    (wr_iclr),
        .count_o    (cnt),
        .raw_o      (raw)
    );

    // read mux
    always_comb begin
        rdata = '0;
        if (acc_ok) begin
            case (reg_off_e'(sel_off))
                OFF_LOAD, OFF_BGLOAD: rdata = regs_q.limit;
                OFF_VALUE:            rdata = cnt;
                OFF_CTRL:             rdata = {24'd0, regs_q.ctrl};
                OFF_RAW:              rdata = {31'd0, raw};
                OFF_MASKED:           rdata = {31'd0, raw & regs_q.ctrl.irq_en};
                default:              rdata = '0;
            endcase
        end
    end

    assign irq = raw && regs_q.ctrl.irq_en;

    AST_UNDEF_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !acc_ok |=> $stable(regs_q)); // R2

    AST_BG_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bg && !regs_q.ctrl.enable |=> $stable(cnt)); // R4

    AST_IRQ_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_iclr && !tick |=> !irq); // R9

endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

    localparam int ADDR_W = 8;
    localparam logic [7:0] A_LOAD = 8'h00, A_VAL = 8'h04, A_CTRL = 8'h08, A_ICLR = 8'h0C,
                           A_RAW  = 8'h10, A_MIS = 8'h14, A_BG   = 8'h18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    interval_timer dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #0.4;
        chk(req, rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] per_val(input int unsigned lim, input int unsigned t);
        return lim - (t % (lim + 1));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd_chk("R1 ctrl", A_CTRL, 32'h20);
        rd_chk("R1 value", A_VAL, 32'h0);
        rd_chk("R1 raw", A_RAW, 32'h0);
        rd_chk("R1 masked", A_MIS, 32'h0);
        rd_chk("R1 load", A_LOAD, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // R2 / R4 register access while stopped
        wr(A_LOAD, 32'hA5A5_1234);
        rd_chk("R4 load reload free16", A_VAL, 32'h0000_FFFF);
        rd_chk("R4 load readback", A_LOAD, 32'hA5A5_1234);
        rd_chk("R4 bg readback", A_BG, 32'hA5A5_1234);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h80, 32'h0000_00FF);
        wr(8'h09, 32'h0000_00FF);
        rd_chk("R2 undef 0x1C", 8'h1C, 32'h0);
        rd_chk("R2 undef 0x80", 8'h80, 32'h0);
        rd_chk("R2 misaligned", 8'h01, 32'h0);
        rd_chk("R2 ctrl kept", A_CTRL, 32'h20);
        rd_chk("R2 load kept", A_LOAD, 32'hA5A5_1234);
        wr(A_VAL, 32'h1);
        rd_chk("R2 value write ignored", A_VAL, 32'h0000_FFFF);
        wr(A_CTRL, 32'h0000_003F);
        rd_chk("R2 ctrl readback", A_CTRL, 32'h3F);
        rd_chk("R10 no reload when off", A_VAL, 32'h0000_FFFF);
        idle(5);
        rd_chk("R10 frozen when off", A_VAL, 32'h0000_FFFF);

        // R3 / R5 prescaler sweep in periodic mode
        for (int sel = 0; sel < 4; sel++) begin
            int unsigned d;
            int unsigned lim;
            int unsigned kmax;
            d    = (sel == 1) ? 16 : ((sel == 2) ? 256 : 1);
            lim  = (sel == 2) ? 2 : 5;
            kmax = d * (lim + 1) * 2 + 3;
            wr(A_CTRL, 32'h22);
            wr(A_ICLR, 32'h0);
            wr(A_LOAD, lim);
            wr(A_CTRL, 32'hE2 | (sel << 2));
            for (int unsigned k = 0; k <= kmax; k++) begin
                int unsigned t;
                t = k / d;
                rd_chk("R3 R5 periodic count", A_VAL, per_val(lim, t));
                rd_chk("R8 raw after zero", A_RAW, (t >= lim) ? 32'h1 : 32'h0);
                idle(1);
            end
        end

        // R6 free-running 16-bit wrap, then 32-bit
        wr(A_CTRL, 32'h20);
        wr(A_ICLR, 32'h0);
        wr(A_LOAD, 32'h55);
        wr(A_CTRL, 32'hA0);
        rd_chk("R6 free16 start", A_VAL, 32'hFFFF);
        idle(100);
        rd_chk("R6 free16 k=100", A_VAL, 32'hFFFF - 100);
        idle(65534 - 100);
        rd_chk("R6 free16 k=65534", A_VAL, 32'h1);
        rd_chk("R8 raw before zero", A_RAW, 32'h0);
        idle(1);
        rd_chk("R6 free16 zero", A_VAL, 32'h0);
        rd_chk("R8 raw at zero", A_RAW, 32'h1);
        chk("R9 irq at zero", {31'd0, irq}, 32'h1);
        idle(1);
        rd_chk("R6 free16 wrap", A_VAL, 32'hFFFF);
        wr(A_CTRL, 32'hA2);
        rd_chk("R6 free32 start", A_VAL, 32'hFFFF_FFFF);
        idle(3);
        rd_chk("R6 free32 k=3", A_VAL, 32'hFFFF_FFFC);

        // R6 16-bit periodic truncation
        wr(A_CTRL, 32'h20);
        wr(A_ICLR, 32'h0);
        wr(A_LOAD, 32'h0001_0003);
        rd_chk("R6 load stored full", A_LOAD, 32'h0001_0003);
        wr(A_CTRL, 32'hE0);
        rd_chk("R6 periodic16 trunc", A_VAL, 32'h3);
        idle(4);
        rd_chk("R6 periodic16 period", A_VAL, 32'h3);

        // R7 one-shot
        wr(A_CTRL, 32'h22);
        wr(A_ICLR, 32'h0);
        wr(A_LOAD, 32'h3);
        wr(A_CTRL, 32'hA3);
        for (int k = 0; k <= 8; k++) begin
            rd_chk("R7 one-shot count", A_VAL, (k >= 3) ? 32'h0 : 32'(3 - k));
            rd_chk("R8 one-shot raw", A_RAW, (k >= 3) ? 32'h1 : 32'h0);
            idle(1);
        end
        wr(A_ICLR, 32'hDEAD);
        rd_chk("R8 clear", A_RAW, 32'h0);
        chk("R9 irq after clear", {31'd0, irq}, 32'h0);
        idle(5);
        rd_chk("R7 parked", A_VAL, 32'h0);
        rd_chk("R7 no second event", A_RAW, 32'h0);
        wr(A_CTRL, 32'hA3);
        rd_chk("R7 R10 re-enable reload", A_VAL, 32'h3);
        idle(1);
        rd_chk("R7 counting again", A_VAL, 32'h2);

        // R9 masking
        wr(A_CTRL, 32'h02);
        wr(A_ICLR, 32'h0);
        wr(A_LOAD, 32'h1);
        wr(A_CTRL, 32'hC2);
        rd_chk("R10 enable reload", A_VAL, 32'h1);
        idle(1);
        rd_chk("R9 raw unmasked", A_RAW, 32'h1);
        rd_chk("R9 masked off", A_MIS, 32'h0);
        chk("R9 irq masked", {31'd0, irq}, 32'h0);
        wr(A_CTRL, 32'hE2);
        rd_chk("R9 masked on", A_MIS, 32'h1);
        chk("R9 irq on", {31'd0, irq}, 32'h1);
        wr(A_CTRL, 32'h22);
        wr(A_ICLR, 32'h0);
        rd_chk("R9 masked after clear", A_MIS, 32'h0);
        rd_chk("R9 raw after clear", A_RAW, 32'h0);
        chk("R9 irq after clear", {31'd0, irq}, 32'h0);

        // R4 load vs background load
        wr(A_CTRL, 32'h62);
        wr(A_LOAD, 32'h7);
        rd_chk("R4 load reload", A_VAL, 32'h7);
        wr(A_BG, 32'h2);
        rd_chk("R4 bg no reload", A_VAL, 32'h7);
        rd_chk("R4 bg at load addr", A_LOAD, 32'h2);
        rd_chk("R4 bg at bg addr", A_BG, 32'h2);
        idle(3);
        rd_chk("R10 frozen", A_VAL, 32'h7);
        wr(A_LOAD, 32'h4);
        wr(A_ICLR, 32'h0);
        wr(A_CTRL, 32'hE2);
        idle(2);
        rd_chk("R5 run", A_VAL, 32'h2);
        wr(A_BG, 32'h9);
        rd_chk("R4 bg during step", A_VAL, 32'h1);
        idle(1);
        rd_chk("R4 reach zero", A_VAL, 32'h0);
        idle(1);
        rd_chk("R4 wrap to bg limit", A_VAL, 32'h9);
        idle(1);
        rd_chk("R4 after wrap", A_VAL, 32'h8);
        wr(A_LOAD, 32'd20);
        rd_chk("R4 load wins over step", A_VAL, 32'd20);
        idle(1);
        rd_chk("R4 step after load", A_VAL, 32'd19);

        // R8 set and clear on the same edge
        wr(A_CTRL, 32'h62);
        wr(A_ICLR, 32'h0);
        wr(A_LOAD, 32'h2);
        wr(A_CTRL, 32'hE2);
        idle(1);
        rd_chk("R8 pre-collision", A_VAL, 32'h1);
        wr(A_ICLR, 32'h1);
        rd_chk("R8 set wins", A_RAW, 32'h1);
        rd_chk("R8 count at zero", A_VAL, 32'h0);
        wr(A_ICLR, 32'h1);
        rd_chk("R8 later clear", A_RAW, 32'h0);
        rd_chk("R5 reload after collision", A_VAL, 32'h2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule